// File: doc/BRIEF.md
# Configurable Macrocell Register Cell

This block is the storage and output stage of one programmable-logic macrocell. Static configuration inputs set its behaviour. They pick where the stored bit comes from, what kind of storage element it acts as, which clock drives it and how that clock may be gated. They also pick what clears or sets it asynchronously, what the pin output and the buried feedback show, and how the output enable is formed.

The cell runs on one fast system clock `clk`. The global clocks and the clock product term are treated as level signals that are sampled on `clk`. A rising edge of the selected source is detected by comparing its level with the level stored one `clk` earlier. The stored bit changes at the `clk` edge that follows the sample in which the rising edge is seen.

The asynchronous clear and preset override the registered view at once, in the same cycle, through combinational logic, and they also force the stored bit. In latch mode, the data flows through to the registered view while the selected clock is high. The system reset `rst` is synchronous and active high.

Top module: `macrocell_reg_cell`

## Requirements
- R1: While `rst` is high at a `clk` edge, the stored bit and the remembered clock level become 0. With no asynchronous force active, the registered view then reads 0.
- R2: The data bit `d` comes from one of three inputs chosen by `cfg_dsrc`: 0 selects `xor_term`, 1 selects `sep_term`, 2 selects `pin_in`, and 3 selects `xor_term`.
- R3: The storage element is selected by `cfg_mode`. Code 0 is D mode: when a qualified rising edge of the selected clock is seen, the stored bit takes the value of `d` at the next `clk` edge. Without such an edge, the stored bit holds.
- R4: In T mode (`cfg_mode`=1), a qualified rising edge inverts the stored bit when `d`=1 and leaves it unchanged when `d`=0.
- R5: In JK mode (`cfg_mode`=2), J is `d` and K is `aux_term`. On a qualified edge, J=0,K=0 holds the bit, J=1,K=0 sets it, J=0,K=1 clears it, and J=1,K=1 inverts it.
- R6: In SR mode (`cfg_mode`=3), S is `d` and R is `aux_term`. On a qualified edge, S=1,R=0 sets the bit, S=0,R=1 clears it, and S=R=0 and S=R=1 both hold it.
- R7: In latch mode (`cfg_mode`=4), while the selected clock level is high, the registered view equals `d` in the same cycle and the stored bit follows `d`. While the level is low, the stored bit holds. Clock enable has no effect in this mode. Mode codes 5 to 7 hold the stored bit.
- R8: `cfg_csrc` values 0 to 2 select `gclk[0]` to `gclk[2]`, and value 3 selects `clk_term`. Only rising edges of the selected source update the stored bit.
- R9: When `cfg_ce_en`=1 and a global clock is selected, rising edges that occur while `ce_term`=0 are ignored. When `clk_term` is the selected clock, `ce_term` is ignored.
- R10: The asynchronous clear source is set by `cfg_arsrc`: 0 is off, 1 is `gclear`, 2 is `ar_term`, and 3 is the OR of both. An active clear makes the registered view 0 in the same cycle and clears the stored bit.
- R11: When `cfg_ap_en`=1 and `ap_term`=1, the preset makes the registered view 1 in the same cycle and sets the stored bit. If a clear is active at the same time, the clear wins.
- R12: `mc_out` shows the registered view when `cfg_out_reg`=1 and `xor_term` when it is 0. `mc_fb` makes the same choice independently, using `cfg_fb_reg`.
- R13: `mc_oe` is set by `cfg_oesel`: 0 gives 0, 1 gives 1, 2 gives `oe_pin[0]`, 3 gives the inverse of `oe_pin[0]`, 4 gives `oe_pin[1]`, and 5 gives the inverse of `oe_pin[1]`. Codes 6 and 7 give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 3 | Storage element type |
| cfg_dsrc | input | 2 | Data source select |
| cfg_csrc | input | 2 | Clock source select |
| cfg_ce_en | input | 1 | Use `ce_term` as clock enable |
| cfg_arsrc | input | 2 | Asynchronous clear source |
| cfg_ap_en | input | 1 | Enable preset from `ap_term` |
| cfg_out_reg | input | 1 | Pin output registered (1) or combinational (0) |
| cfg_fb_reg | input | 1 | Feedback registered (1) or combinational (0) |
| cfg_oesel | input | 3 | Output enable select |
| xor_term | input | 1 | XOR-path logic result |
| sep_term | input | 1 | Separate data product term |
| pin_in | input | 1 | Pin input |
| aux_term | input | 1 | K / R input for JK and SR modes |
| gclk | input | 3 | Global clock levels |
| clk_term | input | 1 | Clock product term level |
| ce_term | input | 1 | Clock enable product term |
| gclear | input | 1 | Global clear |
| ar_term | input | 1 | Clear product term |
| ap_term | input | 1 | Preset product term |
| oe_pin | input | 2 | Output-enable pins |
| mc_out | output | 1 | Pin output |
| mc_fb | output | 1 | Buried feedback |
| mc_oe | output | 1 | Output enable |

## Verification
A wrong stored bit stays hidden while the outputs are combinational or a force is active. It appears on `mc_out` or `mc_fb` in the first cycle in which a registered path is selected and no clear or preset is active. A wrong edge detector or a wrong enable gate shows one `clk` cycle after the clock sample that should, or should not, have updated the bit. A clear or preset decode error shows in the same cycle, because those paths are combinational. The bench therefore compares all three outputs every cycle against a model that steps once per `clk`.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [2:0] {
        MODE_D     = 3'd0,
        MODE_T     = 3'd1,
        MODE_JK    = 3'd2,
        MODE_SR    = 3'd3,
        MODE_LATCH = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        DIN_XOR  = 2'd0,
        DIN_SEP  = 2'd1,
        DIN_PIN  = 2'd2,
        DIN_XOR2 = 2'd3
    } din_e;

    typedef enum logic [1:0] {
        CLR_OFF    = 2'd0,
        CLR_GLOBAL = 2'd1,
        CLR_TERM   = 2'd2,
        CLR_EITHER = 2'd3
    } clr_e;

    typedef enum logic [2:0] {
        OE_NEVER  = 3'd0,
        OE_ALWAYS = 3'd1,
        OE_A      = 3'd2,
        OE_A_N    = 3'd3,
        OE_B      = 3'd4,
        OE_B_N    = 3'd5
    } oe_e;

    typedef struct packed {
        logic clr;
        logic pre;
    } force_t;

    // Next stored value on a qualified edge for the edge-triggered modes.
    function automatic logic edge_next(mode_e m, logic q, logic a, logic b);
        logic n;
        case (m)
            MODE_D:  n = a;
            MODE_T:  n = q ^ a;
            MODE_JK: n = (a & ~q) | (~b & q);
            MODE_SR: n = (a & ~b) ? 1'b1 : ((~a & b) ? 1'b0 : q);
            default: n = q;
        endcase
        return n;
    endfunction

    function automatic logic pick_data(din_e s, logic x, logic p, logic pin);
        logic r;
        case (s)
            DIN_SEP: r = p;
            DIN_PIN: r = pin;
            default: r = x;
        endcase
        return r;
    endfunction

    function automatic force_t decode_force(clr_e s, logic gc, logic ct,
                                            logic pen, logic pt);
        force_t f;
        case (s)
            CLR_GLOBAL: f.clr = gc;
            CLR_TERM:   f.clr = ct;
            CLR_EITHER: f.clr = gc | ct;
            default:    f.clr = 1'b0;
        endcase
        f.pre = pen & pt;
        return f;
    endfunction

    function automatic logic pick_oe(oe_e s, logic [1:0] pins);
        logic r;
        case (s)
            OE_ALWAYS: r = 1'b1;
            OE_A:      r = pins[0];
            OE_A_N:    r = ~pins[0];
            OE_B:      r = pins[1];
            OE_B_N:    r = ~pins[1];
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mc_clock_select.sv
module mc_clock_select #(
    parameter int NUM_GCLK = 3,
    localparam int CSEL_W = $clog2(NUM_GCLK + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic                clk_term,
    input  logic [CSEL_W-1:0]   csel,
    input  logic                ce_en,
    input  logic                ce_term,
    output logic                clk_level,
    output logic                edge_fire
);
    logic use_global;
    logic level_q;
    logic gate_ok;

    always_comb begin
        clk_level = clk_term;
        for (int i = 0; i < NUM_GCLK; i++) begin
            if (int'(csel) == i) clk_level = gclk[i];
        end
    end

    assign use_global = int'(csel) < NUM_GCLK;
    assign gate_ok    = ~(ce_en & use_global) | ce_term;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= clk_level;
    end

    assign edge_fire = clk_level & ~level_q & gate_ok;
endmodule

// File: rtl/mc_storage.sv
module mc_storage
    import mc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  mode_e  mode,
    input  logic   d,
    input  logic   aux,
    input  logic   clk_level,
    input  logic   edge_fire,
    input  force_t frc,
    output logic   st_q,
    output logic   reg_view
);
    always_ff @(posedge clk) begin
        if (rst)                    st_q <= 1'b0;
        else if (frc.clr)           st_q <= 1'b0;
        else if (frc.pre)           st_q <= 1'b1;
        else if (mode == MODE_LATCH) begin
            if (clk_level)          st_q <= d;
        end
        else if (edge_fire)         st_q <= edge_next(mode, st_q, d, aux);
    end

    always_comb begin
        if (frc.clr)                            reg_view = 1'b0;
        else if (frc.pre)                       reg_view = 1'b1;
        else if (mode == MODE_LATCH && clk_level) reg_view = d;
        else                                    reg_view = st_q;
    end
endmodule

// File: rtl/mc_output_mux.sv
module mc_output_mux
    import mc_pkg::*;
(
    input  logic       reg_view,
    input  logic       comb_val,
    input  logic       out_reg,
    input  logic       fb_reg,
    input  oe_e        oesel,
    input  logic [1:0] oe_pins,
    output logic       mc_out,
    output logic       mc_fb,
    output logic       mc_oe
);
    assign mc_out = out_reg ? reg_view : comb_val;
    assign mc_fb  = fb_reg  ? reg_view : comb_val;
    assign mc_oe  = pick_oe(oesel, oe_pins);
endmodule

// File: rtl/macrocell_reg_cell.sv
module macrocell_reg_cell
    import mc_pkg::*;
#(
    parameter int NUM_GCLK = 3,
    localparam int CSEL_W = $clog2(NUM_GCLK + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          cfg_mode,
    input  logic [1:0]          cfg_dsrc,
    input  logic [CSEL_W-1:0]   cfg_csrc,
    input  logic                cfg_ce_en,
    input  logic [1:0]          cfg_arsrc,
    input  logic                cfg_ap_en,
    input  logic                cfg_out_reg,
    input  logic                cfg_fb_reg,
    input  logic [2:0]          cfg_oesel,
    input  logic                xor_term,
    input  logic                sep_term,
    input  logic                pin_in,
    input  logic                aux_term,
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic                clk_term,
    input  logic                ce_term,
    input  logic                gclear,
    input  logic                ar_term,
    input  logic                ap_term,
    input  logic [1:0]          oe_pin,
    output logic                mc_out,
    output logic                mc_fb,
    output logic                mc_oe
);
    logic   d_sel;
    logic   clk_level;
    logic   edge_fire;
    logic   st_q;
    logic   reg_view;
    force_t frc;
    logic   ar_act;
    logic   ap_act;

    assign d_sel  = pick_data(din_e'(cfg_dsrc), xor_term, sep_term, pin_in);
    assign frc    = decode_force(clr_e'(cfg_arsrc), gclear, ar_term, cfg_ap_en, ap_term);
    assign ar_act = frc.clr;
    assign ap_act = frc.pre;

    mc_clock_select #(.NUM_GCLK(NUM_GCLK)) u_clk (
        .clk       (clk),
        .rst       (rst),
        .gclk      (gclk),
        .clk_term  (clk_term),
        .csel      (cfg_csrc),
        .ce_en     (cfg_ce_en),
        .ce_term   (ce_term),
        .clk_level (clk_level),
        .edge_fire (edge_fire)
    );

    mc_storage u_store (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_e'(cfg_mode)),
        .d         (d_sel),
        .aux       (aux_term),
        .clk_level (clk_level),
        .edge_fire (edge_fire),
        .frc       (frc),
        .st_q      (st_q),
        .reg_view  (reg_view)
    );

    mc_output_mux u_out (
        .reg_view (reg_view),
        .comb_val (xor_term),
        .out_reg  (cfg_out_reg),
        .fb_reg   (cfg_fb_reg),
        .oesel    (oe_e'(cfg_oesel)),
        .oe_pins  (oe_pin),
        .mc_out   (mc_out),
        .mc_fb    (mc_fb),
        .mc_oe    (mc_oe)
    );
endmodule

// File: rtl/macrocell_reg_cell_chk.sv
module macrocell_reg_cell_chk #(
    parameter int NUM_GCLK = 3,
    localparam int CSEL_W = $clog2(NUM_GCLK + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        cfg_mode,
    input logic [CSEL_W-1:0] cfg_csrc,
    input logic              cfg_ce_en,
    input logic              ce_term,
    input logic              ar_act,
    input logic              ap_act,
    input logic              edge_fire,
    input logic              clk_level,
    input logic              d_sel,
    input logic              st_q,
    input logic [2:0]        cfg_oesel,
    input logic              mc_oe
);
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (st_q == 1'b0));

    p_d_load_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 3'd0 && edge_fire && !ar_act && !ap_act) |=> (st_q == $past(d_sel)));

    p_latch_follow_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 3'd4 && clk_level && !ar_act && !ap_act) |=> (st_q == $past(d_sel)));

    p_enable_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode != 3'd4 && cfg_ce_en && int'(cfg_csrc) < NUM_GCLK && !ce_term
         && !ar_act && !ap_act) |=> $stable(st_q));

    p_clear_forces_r10: assert property (@(posedge clk) disable iff (rst)
        ar_act |=> (st_q == 1'b0));

    p_preset_forces_r11: assert property (@(posedge clk) disable iff (rst)
        (ap_act && !ar_act) |=> (st_q == 1'b1));

    p_oe_never_r13: assert property (@(posedge clk) disable iff (rst)
        (cfg_oesel == 3'd0) |-> !mc_oe);
endmodule

bind macrocell_reg_cell macrocell_reg_cell_chk #(.NUM_GCLK(NUM_GCLK)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_mode  (cfg_mode),
    .cfg_csrc  (cfg_csrc),
    .cfg_ce_en (cfg_ce_en),
    .ce_term   (ce_term),
    .ar_act    (ar_act),
    .ap_act    (ap_act),
    .edge_fire (edge_fire),
    .clk_level (clk_level),
    .d_sel     (d_sel),
    .st_q      (st_q),
    .cfg_oesel (cfg_oesel),
    .mc_oe     (mc_oe)
);

// File: tb/tb_macrocell_reg_cell.sv
`timescale 1ns/1ps
module tb_macrocell_reg_cell;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cfg_mode = 3'd0;
    logic [1:0] cfg_dsrc = 2'd0;
    logic [1:0] cfg_csrc = 2'd0;
    logic       cfg_ce_en = 1'b0;
    logic [1:0] cfg_arsrc = 2'd0;
    logic       cfg_ap_en = 1'b0;
    logic       cfg_out_reg = 1'b1;
    logic       cfg_fb_reg = 1'b1;
    logic [2:0] cfg_oesel = 3'd0;
    logic       xor_term = 1'b0, sep_term = 1'b0, pin_in = 1'b0, aux_term = 1'b0;
    logic [2:0] gclk = 3'd0;
    logic       clk_term = 1'b0, ce_term = 1'b0, gclear = 1'b0;
    logic       ar_term = 1'b0, ap_term = 1'b0;
    logic [1:0] oe_pin = 2'd0;
    logic       mc_out, mc_fb, mc_oe;

    int checks = 0;
    int errors = 0;
    logic m_st = 1'b0;
    logic m_prev = 1'b0;

    always #5 clk = ~clk;

    macrocell_reg_cell dut (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_dsrc(cfg_dsrc),
        .cfg_csrc(cfg_csrc), .cfg_ce_en(cfg_ce_en), .cfg_arsrc(cfg_arsrc),
        .cfg_ap_en(cfg_ap_en), .cfg_out_reg(cfg_out_reg), .cfg_fb_reg(cfg_fb_reg),
        .cfg_oesel(cfg_oesel), .xor_term(xor_term), .sep_term(sep_term),
        .pin_in(pin_in), .aux_term(aux_term), .gclk(gclk), .clk_term(clk_term),
        .ce_term(ce_term), .gclear(gclear), .ar_term(ar_term), .ap_term(ap_term),
        .oe_pin(oe_pin), .mc_out(mc_out), .mc_fb(mc_fb), .mc_oe(mc_oe)
    );

    function automatic logic m_data();
        case (cfg_dsrc)
            2'd1: return sep_term;
            2'd2: return pin_in;
            default: return xor_term;
        endcase
    endfunction

    function automatic logic m_level();
        return (cfg_csrc == 2'd3) ? clk_term : gclk[cfg_csrc];
    endfunction

    function automatic logic m_clr();
        case (cfg_arsrc)
            2'd1: return gclear;
            2'd2: return ar_term;
            2'd3: return gclear | ar_term;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic m_view();
        if (m_clr()) return 1'b0;
        if (cfg_ap_en && ap_term) return 1'b1;
        if (cfg_mode == 3'd4 && m_level()) return m_data();
        return m_st;
    endfunction

    function automatic logic m_oe();
        case (cfg_oesel)
            3'd1: return 1'b1;
            3'd2: return oe_pin[0];
            3'd3: return ~oe_pin[0];
            3'd4: return oe_pin[1];
            3'd5: return ~oe_pin[1];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic m_next();
        logic dd, kk, ce_ok, rise;
        dd = m_data();
        kk = aux_term;
        rise = m_level() & ~m_prev;
        ce_ok = !(cfg_ce_en && cfg_csrc != 2'd3) || ce_term;
        if (m_clr()) return 1'b0;
        if (cfg_ap_en && ap_term) return 1'b1;
        if (cfg_mode == 3'd4) return m_level() ? dd : m_st;
        if (!(rise && ce_ok)) return m_st;
        case (cfg_mode)
            3'd0: return dd;
            3'd1: return dd ? ~m_st : m_st;
            3'd2: begin
                if (dd && kk) return ~m_st;
                if (dd) return 1'b1;
                if (kk) return 1'b0;
                return m_st;
            end
            3'd3: begin
                if (dd && !kk) return 1'b1;
                if (!dd && kk) return 1'b0;
                return m_st;
            end
            default: return m_st;
        endcase
    endfunction

    // Inputs are set just after a negedge; check, then advance the model over one posedge.
    task automatic step(input string tag);
        logic [2:0] exp_v, act_v;
        logic nxt, lvl;
        #1;
        exp_v = {cfg_out_reg ? m_view() : xor_term,
                 cfg_fb_reg ? m_view() : xor_term, m_oe()};
        act_v = {mc_out, mc_fb, mc_oe};
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: {out,fb,oe} actual=%b expected=%b", tag, act_v, exp_v);
        end
        nxt = m_next();
        lvl = m_level();
        @(posedge clk);
        m_st = nxt;
        m_prev = lvl;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        m_st = 1'b0;
        m_prev = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic set_cfg(input logic [2:0] md, input logic [1:0] cs);
        cfg_mode = md; cfg_csrc = cs; cfg_dsrc = 2'd0; cfg_ce_en = 1'b0;
        cfg_arsrc = 2'd0; cfg_ap_en = 1'b0; cfg_out_reg = 1'b1; cfg_fb_reg = 1'b1;
        cfg_oesel = 3'd1; gclk = 3'd0; clk_term = 1'b0; gclear = 1'b0;
        ar_term = 1'b0; ap_term = 1'b0; ce_term = 1'b0;
    endtask

    // One rising edge on gclk[0]: high for one step, then low for one step.
    task automatic pulse0(input string tag);
        gclk[0] = 1'b1; step(tag);
        gclk[0] = 1'b0; step(tag);
    endtask

    function automatic string mode_tag(input logic [2:0] md);
        case (md)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R1: load a 1, then reset clears it.
        set_cfg(3'd0, 2'd0);
        xor_term = 1'b1; pulse0("R3");
        do_reset();
        xor_term = 1'b0; step("R1");

        // R2: each data source in D mode.
        for (int s = 0; s < 4; s++) begin
            cfg_dsrc = 2'(s);
            xor_term = (s == 0 || s == 3); sep_term = (s == 1); pin_in = (s == 2);
            pulse0("R2");
            xor_term = ~xor_term; sep_term = ~sep_term; pin_in = ~pin_in;
            pulse0("R2");
        end
        cfg_dsrc = 2'd0;

        // R4: toggle behaviour.
        set_cfg(3'd1, 2'd0);
        xor_term = 1'b1; pulse0("R4"); pulse0("R4");
        xor_term = 1'b0; pulse0("R4");

        // R5: all JK combinations.
        set_cfg(3'd2, 2'd0);
        for (int c = 0; c < 8; c++) begin
            xor_term = c[0]; aux_term = c[1]; pulse0("R5");
        end

        // R6: all SR combinations, including S=R=1 hold.
        set_cfg(3'd3, 2'd0);
        xor_term = 1'b1; aux_term = 1'b0; pulse0("R6");
        xor_term = 1'b1; aux_term = 1'b1; pulse0("R6");
        xor_term = 1'b0; aux_term = 1'b1; pulse0("R6");
        xor_term = 1'b1; aux_term = 1'b1; pulse0("R6");
        xor_term = 1'b0; aux_term = 1'b0; pulse0("R6");

        // R7: latch is transparent while high, even with enable low.
        set_cfg(3'd4, 2'd1);
        cfg_ce_en = 1'b1; ce_term = 1'b0;
        gclk[1] = 1'b1; xor_term = 1'b1; step("R7");
        xor_term = 1'b0; step("R7");
        xor_term = 1'b1; step("R7");
        gclk[1] = 1'b0; xor_term = 1'b0; step("R7");
        step("R7");
        cfg_mode = 3'd6; gclk[1] = 1'b1; xor_term = 1'b0; step("R7"); step("R7");

        // R8: other clocks toggle while gclk[2] or clk_term is selected.
        set_cfg(3'd0, 2'd2);
        xor_term = 1'b1; gclk[0] = 1'b1; gclk[1] = 1'b1; clk_term = 1'b1; step("R8");
        gclk = 3'b100; step("R8"); step("R8");
        cfg_csrc = 2'd3; xor_term = 1'b0; gclk = 3'b000; clk_term = 1'b0; step("R8");
        gclk = 3'b111; step("R8");
        clk_term = 1'b1; step("R8"); step("R8");

        // R9: enable gates a global clock, not the product-term clock.
        set_cfg(3'd0, 2'd0);
        cfg_ce_en = 1'b1; ce_term = 1'b0; xor_term = 1'b1;
        pulse0("R9"); pulse0("R9");
        ce_term = 1'b1; pulse0("R9");
        cfg_csrc = 2'd3; ce_term = 1'b0; xor_term = 1'b0;
        clk_term = 1'b1; step("R9"); clk_term = 1'b0; step("R9");

        // R10: each clear source.
        for (int a = 1; a < 4; a++) begin
            set_cfg(3'd0, 2'd0);
            xor_term = 1'b1; pulse0("R10");
            cfg_arsrc = 2'(a); gclear = 1'b1; step("R10");
            gclear = 1'b0; ar_term = 1'b1; step("R10");
            ar_term = 1'b0; step("R10");
        end
        set_cfg(3'd0, 2'd0);
        cfg_arsrc = 2'd0; gclear = 1'b1; ar_term = 1'b1; step("R10");

        // R11: preset, and clear wins over preset.
        set_cfg(3'd0, 2'd0);
        cfg_ap_en = 1'b1; ap_term = 1'b1; step("R11"); step("R11");
        cfg_arsrc = 2'd1; gclear = 1'b1; step("R11"); step("R11");
        gclear = 1'b0; ap_term = 1'b0; step("R11");
        cfg_ap_en = 1'b0; ap_term = 1'b1; step("R11");

        // R12: independent output and feedback paths.
        set_cfg(3'd0, 2'd0);
        xor_term = 1'b1; pulse0("R12");
        xor_term = 1'b0;
        for (int o = 0; o < 4; o++) begin
            cfg_out_reg = o[0]; cfg_fb_reg = o[1]; step("R12");
            xor_term = ~xor_term; step("R12");
        end

        // R13: every output-enable code against every pin pattern.
        for (int e = 0; e < 8; e++) begin
            for (int p = 0; p < 4; p++) begin
                cfg_oesel = 3'(e); oe_pin = 2'(p); step("R13");
            end
        end

        // Random configurations held static, random inputs each cycle.
        for (int n = 0; n < 40; n++) begin
            cfg_mode = 3'($urandom % 5); cfg_dsrc = 2'($urandom);
            cfg_csrc = 2'($urandom); cfg_ce_en = 1'($urandom);
            cfg_arsrc = 2'($urandom); cfg_ap_en = 1'($urandom);
            cfg_out_reg = 1'($urandom); cfg_fb_reg = 1'($urandom);
            cfg_oesel = 3'($urandom);
            do_reset();
            for (int k = 0; k < 80; k++) begin
                xor_term = 1'($urandom); sep_term = 1'($urandom);
                pin_in = 1'($urandom); aux_term = 1'($urandom);
                gclk = 3'($urandom); clk_term = 1'($urandom);
                ce_term = 1'($urandom); oe_pin = 2'($urandom);
                gclear = ($urandom % 8) == 0; ar_term = ($urandom % 8) == 0;
                ap_term = ($urandom % 6) == 0;
                step(mode_tag(cfg_mode));
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule